// File: doc/BRIEF.md
# Zoned TLB Lookup Unit

This block is the lookup stage of a fully associative translation lookaside buffer. A request carries a 32-bit virtual address, an access kind (read, write or execute) and a flag that marks a user-mode access. The unit compares the request against every entry of a small tag/data array at once. Each entry has its own page size, from 1 KiB to 16 MiB, and an optional process tag. The unit returns one of three results: a hit, a miss, or a protection fault. It also returns the index of the deciding entry, the translated physical address and the page size code.

A global zone register can override an entry's own permission bits. Each entry names one of up to sixteen zones. The zone's two-bit code can do one of three things: hide the entry from user accesses, leave the entry's own rights in force, or grant full write and execute rights. Entries are loaded and replaced elsewhere. This unit only reads them, through one flat read port per entry, together with the current process ID and the zone register.

Requests enter through a valid/ready port and results leave through a valid/ready port with a single register stage between them. `req_ready_o` is high whenever the output register is empty or is being drained in the same cycle. A result that is not accepted stays on the outputs unchanged, and the unit then takes no new request. The entry array, the process ID and the zone register are sampled in the cycle the request is accepted.

Top module: `ztlb_lookup`

## Requirements
- R1: The tag word holds the effective page number in bits 31:10, the page-size code in bits 9:7 and the valid flag in bit 6. Size codes 0 through 7 give 1 KiB, 4 KiB, 16 KiB, 64 KiB, 256 KiB, 1 MiB, 4 MiB and 16 MiB, and the result's size output carries this code.
- R2: An entry takes part only when its valid bit is set and the virtual address equals the tag address once all bits below the page size are cleared from both.
- R3: An entry whose process tag is nonzero takes part only when the tag equals `pid_i`. A process tag of zero matches every process ID.
- R4: The data word holds the real page number in bits 31:10, the execute right in bit 9, the write right in bit 8 and the zone select in bits 7:4. Zone z takes its code from zone register bits (31-2z):(30-2z). Code 0 makes the entry invisible to user accesses, and the search then continues to higher indices.
- R5: Zone code 1 keeps the entry's own write and execute rights. Code 2 grants both rights to non-user accesses only. Code 3 grants both rights to every access.
- R6: The zone code is forced to 1 when the zone select is greater than parameter `ZONE_MAX`. It is also forced to 1 for every entry when parameter `ZONES_EN` is 0.
- R7: Access codes are 0 read, 1 write, 2 execute and 3 read. A write to an entry without the write right is a protection fault. An execute from an entry without the execute right is a protection fault. A read is never refused.
- R8: The lowest-index entry that passes the checks of R2, R3 and R4 decides the result. When no entry passes, the result is a miss and the index output is 0.
- R9: Each result raises exactly one of hit, miss and fault. On a hit the physical address is the real page number with the address bits below the page size taken from the virtual address. On a miss or a fault the address and size outputs are 0, and a fault reports the deciding index.
- R10: A result appears on the outputs in the cycle after its request is accepted. `req_ready_o` equals `!rsp_valid_o || rsp_ready_i`. While `rsp_valid_o` is high and `rsp_ready_i` is low, every result output holds its value.
- R11: After reset `rsp_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_tag_i | input | 32*NENT | Tag word of each entry, entry i in bits 32i+31:32i |
| ent_data_i | input | 32*NENT | Data word of each entry |
| ent_tid_i | input | TID_W*NENT | Process tag of each entry |
| pid_i | input | TID_W | Current process ID |
| zone_reg_i | input | 32 | Zone code register |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_vaddr_i | input | 32 | Virtual address |
| req_acc_i | input | 2 | Access kind |
| req_user_i | input | 1 | High for a user-mode access |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Result taken |
| rsp_hit_o | output | 1 | Translation found |
| rsp_miss_o | output | 1 | No entry passed |
| rsp_fault_o | output | 1 | Protection fault |
| rsp_idx_o | output | log2(NENT) | Deciding entry index |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_size_o | output | 3 | Page size code |

## Verification
The bench sends addresses that share one page between a supervisor-only entry and a process-tagged entry behind it. This tells the zone-0 hiding and the process-tag filter apart from plain index priority. Lookups in 1 KiB, 1 MiB and 16 MiB pages, at the first and last byte and just outside each page, separate correct size masking and offset merging from off-by-one masks. Write and execute requests under every zone code, with the zone select set past the configured limit, and a second instance built without zones, show whether rights are granted, refused or overridden. A stalled result with a second request waiting checks the hold behaviour and the handover from one result to the next.

// File: rtl/ztlb_pkg.sv
package ztlb_pkg;

  localparam int VA_W      = 32;
  localparam int PG_LSB    = 10;
  localparam int SZ_LSB    = 7;
  localparam int VLD_BIT   = 6;
  localparam int EX_BIT    = 9;
  localparam int WR_BIT    = 8;
  localparam int ZS_LSB    = 4;
  localparam int ZS_W      = 4;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RD2 = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    ZC_NOUSER = 2'd0,
    ZC_OWN    = 2'd1,
    ZC_SUPALL = 2'd2,
    ZC_ALL    = 2'd3
  } zcode_e;

  // Byte offset mask of a page: 1 KiB scaled by 4 per size step.
  function automatic logic [VA_W-1:0] off_mask(input logic [2:0] code);
    logic [VA_W-1:0] span;
    span = VA_W'(1 << PG_LSB) << {code, 1'b0};
    return span - VA_W'(1);
  endfunction

endpackage

// File: rtl/ztlb_prio.sv
module ztlb_prio #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);

  // Scan from the top so the lowest set bit is written last.
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/ztlb_entry_cmp.sv
module ztlb_entry_cmp
  import ztlb_pkg::*;
#(
  parameter int TID_W    = 8,
  parameter bit ZONES_EN = 1'b1,
  parameter int ZONE_MAX = 15
) (
  input  logic [31:0]      tag_i,
  input  logic [31:0]      data_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [31:0]      vaddr_i,
  input  logic [TID_W-1:0] pid_i,
  input  logic [31:0]      zone_reg_i,
  input  logic             user_i,
  input  logic [1:0]       acc_i,
  output logic             sel_o,
  output logic             perm_ok_o,
  output logic [31:0]      paddr_o,
  output logic [2:0]       size_o
);

  logic [31:0]     omask;
  logic [31:0]     epn;
  logic [31:0]     rpn;
  logic            addr_eq;
  logic            tid_ok;
  logic [ZS_W-1:0] zsel;
  zcode_e          zc;
  logic            visible;
  logic            wr_ok;
  logic            ex_ok;
  acc_e            acc;
  logic            unused_bits;

  assign size_o  = tag_i[SZ_LSB +: 3];
  assign omask   = off_mask(size_o);
  assign epn     = {tag_i[31:PG_LSB], {PG_LSB{1'b0}}};
  assign rpn     = {data_i[31:PG_LSB], {PG_LSB{1'b0}}};
  assign addr_eq = ((vaddr_i & ~omask) == (epn & ~omask));
  assign tid_ok  = (tid_i == '0) || (tid_i == pid_i);
  assign zsel    = data_i[ZS_LSB +: ZS_W];
  assign unused_bits = ^{tag_i[5:0], data_i[3:0]};

  generate
    if (ZONES_EN) begin : g_zones
      logic [31:0] shifted;
      assign shifted = zone_reg_i >> (5'd30 - {zsel, 1'b0});
      always_comb begin
        if (int'(zsel) > ZONE_MAX) zc = ZC_OWN;
        else                       zc = zcode_e'(shifted[1:0]);
      end
    end else begin : g_nozones
      logic unused_zone;
      assign unused_zone = ^{zone_reg_i, zsel};
      assign zc = ZC_OWN;
    end
  endgenerate

  assign visible = !(zc == ZC_NOUSER && user_i);
  assign sel_o   = tag_i[VLD_BIT] && addr_eq && tid_ok && visible;

  always_comb begin
    wr_ok = data_i[WR_BIT];
    ex_ok = data_i[EX_BIT];
    if (zc == ZC_ALL || (zc == ZC_SUPALL && !user_i)) begin
      wr_ok = 1'b1;
      ex_ok = 1'b1;
    end
  end

  assign acc       = acc_e'(acc_i);
  assign perm_ok_o = !((acc == ACC_WR) && !wr_ok) && !((acc == ACC_EX) && !ex_ok);
  assign paddr_o   = (rpn & ~omask) | (vaddr_i & omask);

endmodule

// File: rtl/ztlb_lookup.sv
module ztlb_lookup
  import ztlb_pkg::*;
#(
  parameter int NENT     = 8,
  parameter int TID_W    = 8,
  parameter bit ZONES_EN = 1'b1,
  parameter int ZONE_MAX = 15,
  localparam int IDX_W   = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [32*NENT-1:0]    ent_tag_i,
  input  logic [32*NENT-1:0]    ent_data_i,
  input  logic [TID_W*NENT-1:0] ent_tid_i,
  input  logic [TID_W-1:0]      pid_i,
  input  logic [31:0]           zone_reg_i,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic [31:0]           req_vaddr_i,
  input  logic [1:0]            req_acc_i,
  input  logic                  req_user_i,
  output logic                  rsp_valid_o,
  input  logic                  rsp_ready_i,
  output logic                  rsp_hit_o,
  output logic                  rsp_miss_o,
  output logic                  rsp_fault_o,
  output logic [IDX_W-1:0]      rsp_idx_o,
  output logic [31:0]           rsp_paddr_o,
  output logic [2:0]            rsp_size_o
);

  logic [NENT-1:0] sel_vec;
  logic [NENT-1:0] perm_vec;
  logic [31:0]     ent_pa [NENT];
  logic [2:0]      ent_sz [NENT];
  logic            any_sel;
  logic [IDX_W-1:0] sel_idx;
  logic            hit_c, fault_c, miss_c;
  logic [31:0]     paddr_c;
  logic [2:0]      size_c;
  logic [IDX_W-1:0] idx_c;
  logic            req_fire;

  generate
    for (genvar g = 0; g < NENT; g++) begin : g_ent
      ztlb_entry_cmp #(
        .TID_W   (TID_W),
        .ZONES_EN(ZONES_EN),
        .ZONE_MAX(ZONE_MAX)
      ) cmp_i (
        .tag_i     (ent_tag_i[32*g +: 32]),
        .data_i    (ent_data_i[32*g +: 32]),
        .tid_i     (ent_tid_i[TID_W*g +: TID_W]),
        .vaddr_i   (req_vaddr_i),
        .pid_i     (pid_i),
        .zone_reg_i(zone_reg_i),
        .user_i    (req_user_i),
        .acc_i     (req_acc_i),
        .sel_o     (sel_vec[g]),
        .perm_ok_o (perm_vec[g]),
        .paddr_o   (ent_pa[g]),
        .size_o    (ent_sz[g])
      );
    end
  endgenerate

  ztlb_prio #(.N(NENT), .IDX_W(IDX_W)) prio_i (
    .req_i(sel_vec),
    .any_o(any_sel),
    .idx_o(sel_idx)
  );

  assign hit_c   = any_sel && perm_vec[sel_idx];
  assign fault_c = any_sel && !perm_vec[sel_idx];
  assign miss_c  = !any_sel;
  assign idx_c   = any_sel ? sel_idx : '0;
  assign paddr_c = hit_c ? ent_pa[sel_idx] : '0;
  assign size_c  = hit_c ? ent_sz[sel_idx] : '0;

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign req_fire    = req_valid_i && req_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_miss_o  <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_idx_o   <= '0;
      rsp_paddr_o <= '0;
      rsp_size_o  <= '0;
    end else if (req_fire) begin
      rsp_valid_o <= 1'b1;
      rsp_hit_o   <= hit_c;
      rsp_miss_o  <= miss_c;
      rsp_fault_o <= fault_c;
      rsp_idx_o   <= idx_c;
      rsp_paddr_o <= paddr_c;
      rsp_size_o  <= size_c;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R8
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && any_sel) |->
      (sel_vec[sel_idx] && ((sel_vec & ((NENT'(1) << sel_idx) - NENT'(1))) == '0)));

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($countones({rsp_hit_o, rsp_miss_o, rsp_fault_o}) == 1));

  // R9
  nohit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_paddr_o == '0 && rsp_size_o == '0));

  // R9
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && hit_c) |-> (paddr_c[PG_LSB-1:0] == req_vaddr_i[PG_LSB-1:0]));

  // R10
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable({rsp_hit_o, rsp_miss_o, rsp_fault_o,
                               rsp_idx_o, rsp_paddr_o, rsp_size_o})));

  // R10
  fire_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid_o);

endmodule

// File: tb/ztlb_lookup_tb_top.sv
`timescale 1ns/1ps
module ztlb_lookup_tb_top;

  localparam int NENT = 8;
  localparam int TW   = 8;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        user;
    logic [7:0]  pid;
    logic [2:0]  kind;   // {fault, hit, miss}
    logic [2:0]  idx;
    logic [31:0] pa;
    logic [2:0]  sz;
  } vec_t;

  localparam logic [2:0] K_MISS = 3'b001;
  localparam logic [2:0] K_HIT  = 3'b010;
  localparam logic [2:0] K_FLT  = 3'b100;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1234, 2'd0, 1'b0, 8'd5, K_HIT,  3'd0, 32'h8000_0234, 3'd1}, // R2 R4 sup sees zone0 entry
    '{32'h0000_1234, 2'd1, 1'b0, 8'd5, K_FLT,  3'd0, 32'h0,         3'd0}, // R7 write no right
    '{32'h0000_1234, 2'd0, 1'b1, 8'd5, K_HIT,  3'd1, 32'h9000_0234, 3'd1}, // R4 R3 user skips to idx1
    '{32'h0000_1234, 2'd1, 1'b1, 8'd3, K_MISS, 3'd0, 32'h0,         3'd0}, // R3 tid mismatch
    '{32'h0010_ABCD, 2'd1, 1'b1, 8'd5, K_HIT,  3'd2, 32'h4000_ABCD, 3'd5}, // R1 R5 1MiB own write
    '{32'h001F_FFFF, 2'd2, 1'b1, 8'd5, K_FLT,  3'd2, 32'h0,         3'd0}, // R5 code2 user no exec
    '{32'h0010_0000, 2'd2, 1'b0, 8'd5, K_HIT,  3'd2, 32'h4000_0000, 3'd5}, // R5 code2 sup grant
    '{32'h0020_0000, 2'd0, 1'b0, 8'd5, K_MISS, 3'd0, 32'h0,         3'd0}, // R2 R8 past page
    '{32'h2012_3456, 2'd1, 1'b1, 8'd7, K_HIT,  3'd4, 32'h0112_3456, 3'd7}, // R1 R2 R5 16MiB, invalid idx3 skipped
    '{32'h2012_3456, 2'd1, 1'b1, 8'd6, K_MISS, 3'd0, 32'h0,         3'd0}, // R3
    '{32'h3000_07FF, 2'd0, 1'b1, 8'd9, K_HIT,  3'd5, 32'h0000_53FF, 3'd0}, // R1 R6 1KiB, zone over limit
    '{32'h3000_0800, 2'd0, 1'b1, 8'd9, K_MISS, 3'd0, 32'h0,         3'd0}, // R1 R2 next 1KiB
    '{32'h3000_07FF, 2'd1, 1'b1, 8'd9, K_FLT,  3'd5, 32'h0,         3'd0}, // R6 R7 forced own rights
    '{32'h0000_1234, 2'd3, 1'b0, 8'd5, K_HIT,  3'd0, 32'h8000_0234, 3'd1}  // R7 code3 is read
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [32*NENT-1:0] tags, datas;
  logic [TW*NENT-1:0] tids;
  logic [7:0]  pid;
  logic [31:0] zreg;
  logic        req_valid, req_ready, req_user, rsp_ready;
  logic [31:0] req_va;
  logic [1:0]  req_acc;
  logic        rsp_valid, hit, miss, fault;
  logic [2:0]  idx, sz;
  logic [31:0] pa;
  logic        nz_ready, nz_valid, nz_hit, nz_miss, nz_fault;
  logic [2:0]  nz_idx, nz_sz;
  logic [31:0] nz_pa;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  ztlb_lookup #(.NENT(NENT), .TID_W(TW), .ZONES_EN(1'b1), .ZONE_MAX(11)) dut_i (
    .clk(clk), .rst_n(rst_n), .ent_tag_i(tags), .ent_data_i(datas), .ent_tid_i(tids),
    .pid_i(pid), .zone_reg_i(zreg), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_vaddr_i(req_va), .req_acc_i(req_acc), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_hit_o(hit), .rsp_miss_o(miss),
    .rsp_fault_o(fault), .rsp_idx_o(idx), .rsp_paddr_o(pa), .rsp_size_o(sz)
  );

  ztlb_lookup #(.NENT(NENT), .TID_W(TW), .ZONES_EN(1'b0), .ZONE_MAX(11)) dut_nz (
    .clk(clk), .rst_n(rst_n), .ent_tag_i(tags), .ent_data_i(datas), .ent_tid_i(tids),
    .pid_i(pid), .zone_reg_i(zreg), .req_valid_i(req_valid), .req_ready_o(nz_ready),
    .req_vaddr_i(req_va), .req_acc_i(req_acc), .req_user_i(req_user),
    .rsp_valid_o(nz_valid), .rsp_ready_i(1'b1), .rsp_hit_o(nz_hit), .rsp_miss_o(nz_miss),
    .rsp_fault_o(nz_fault), .rsp_idx_o(nz_idx), .rsp_paddr_o(nz_pa), .rsp_size_o(nz_sz)
  );

  function automatic logic [31:0] mk_tag(logic [31:0] va, logic [2:0] s, logic v);
    return (va & 32'hFFFF_FC00) | (32'(s) << 7) | (32'(v) << 6);
  endfunction

  function automatic logic [31:0] mk_dat(logic [31:0] p, logic ex, logic wr, logic [3:0] z);
    return (p & 32'hFFFF_FC00) | (32'(ex) << 9) | (32'(wr) << 8) | (32'(z) << 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic lookup(logic [31:0] va, logic [1:0] acc, logic user, logic [7:0] p);
    @(negedge clk);
    req_va = va; req_acc = acc; req_user = user; pid = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tags = '0; datas = '0; tids = '0;
    tags[32*0 +: 32]  = mk_tag(32'h0000_1000, 3'd1, 1'b1);
    datas[32*0 +: 32] = mk_dat(32'h8000_0000, 1'b0, 1'b0, 4'd0);
    tags[32*1 +: 32]  = mk_tag(32'h0000_1000, 3'd1, 1'b1);
    datas[32*1 +: 32] = mk_dat(32'h9000_0000, 1'b1, 1'b1, 4'd1);
    tids[TW*1 +: TW]  = 8'd5;
    tags[32*2 +: 32]  = mk_tag(32'h0010_0000, 3'd5, 1'b1);
    datas[32*2 +: 32] = mk_dat(32'h4000_0000, 1'b0, 1'b1, 4'd2);
    tags[32*3 +: 32]  = mk_tag(32'h2000_0000, 3'd7, 1'b0);
    datas[32*3 +: 32] = mk_dat(32'h7000_0000, 1'b1, 1'b1, 4'd3);
    tags[32*4 +: 32]  = mk_tag(32'h2000_0000, 3'd7, 1'b1);
    datas[32*4 +: 32] = mk_dat(32'h0100_0000, 1'b1, 1'b0, 4'd3);
    tids[TW*4 +: TW]  = 8'd7;
    tags[32*5 +: 32]  = mk_tag(32'h3000_0400, 3'd0, 1'b1);
    datas[32*5 +: 32] = mk_dat(32'h0000_5000, 1'b0, 1'b0, 4'd15);
    zreg = 32'h1B00_0000;   // zones 0..3 hold codes 0,1,2,3; zone 15 code 0
    pid = 8'd5; req_valid = 1'b0; req_va = '0; req_acc = '0; req_user = 1'b0;
    rsp_ready = 1'b1;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R11 req_ready after reset", 32'(req_ready), 32'd1);

    for (int v = 0; v < NV; v++) begin
      lookup(VECS[v].va, VECS[v].acc, VECS[v].user, VECS[v].pid);
      check($sformatf("R10 vec%0d valid", v), 32'(rsp_valid), 32'd1);
      check($sformatf("R2/R3/R4/R5/R7/R8 vec%0d result", v),
            32'({fault, hit, miss}), 32'(VECS[v].kind));
      check($sformatf("R8 vec%0d index", v), 32'(idx), 32'(VECS[v].idx));
      check($sformatf("R9 vec%0d paddr", v), pa, VECS[v].pa);
      check($sformatf("R1 vec%0d size", v), 32'(sz), 32'(VECS[v].sz));
    end

    // R6 no-zone build: zone-0 entry visible to user, read hit idx0
    lookup(32'h0000_1234, 2'd0, 1'b1, 8'd5);
    check("R6 nozone user read", 32'({nz_fault, nz_hit, nz_miss, nz_idx}), {26'd0, K_HIT, 3'd0});
    check("R6 nozone paddr", nz_pa, 32'h8000_0234);
    // R6 no-zone build: code-3 grant gone, write faults on idx4
    lookup(32'h2012_3456, 2'd1, 1'b1, 8'd7);
    check("R6 nozone write fault", 32'({nz_fault, nz_hit, nz_miss, nz_idx}), {26'd0, K_FLT, 3'd4});

    // R10 back-pressure: result held, next request waits
    @(negedge clk);
    rsp_ready = 1'b0;
    lookup(32'h0000_1234, 2'd0, 1'b0, 8'd7);
    check("R10 stalled valid", 32'(rsp_valid), 32'd1);
    check("R10 stalled ready", 32'(req_ready), 32'd0);
    req_va = 32'h2012_3456; req_acc = 2'd1; req_user = 1'b1; req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 held result", {pa[31:3], idx}, {29'(32'h8000_0234 >> 3), 3'd0});
    check("R10 held kind", 32'({fault, hit, miss}), 32'(K_HIT));
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 handover result", 32'({fault, hit, miss, idx}), {26'd0, K_HIT, 3'd4});
    check("R10 handover paddr", pa, 32'h0112_3456);
    @(negedge clk);
    check("R10 drained", 32'(rsp_valid), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule